// File: doc/BRIEF.md
# Segmented Two-Bank Memory Access Unit

This unit sits between a byte-addressed processor core and a 16-bit wide memory made of two byte banks. The even bank holds the bytes at even addresses and carries data bits 7..0. The odd bank holds the bytes at odd addresses and carries bits 15..8. The core presents a read or write request of one byte or one 16-bit word. Each request carries a 16-bit segment and a 16-bit offset. The unit shifts the segment left by four bits, adds the offset, and keeps the low 20 bits as the linear byte address.

The memory only ever receives word addresses, which means the linear address with bit 0 dropped. Bit 0 picks the bank, and each bank has its own enable bit. A word that starts on an odd byte spans two memory words. The unit therefore splits it into two bus operations and moves each byte to the correct half of the core's data path. Words are little endian: the low byte sits at the given address.

The memory port is synchronous. A bus operation is presented for one cycle with `mem_en` high, and read data appears on `mem_rdata` in the cycle after that. The core side uses a request, busy and done handshake.

Top module: `segbank_access`

## Requirements
- R1: The linear address is (segment × 16 + offset) taken modulo 2^20. Every bus operation drives `mem_addr` with bits 19..1 of the byte address it covers.
- R2: Wraparound is handled at both ends. A segment/offset sum of 2^20 or more wraps to the bottom of the space. The second half of an odd word at linear address 0xFFFFF goes to word address 0.
- R3: A byte read uses one bus operation with exactly one bank enabled. `mem_be` is 2'b01 for an even address and 2'b10 for an odd address. The byte is returned in `rdata[7:0]`, with `rdata[15:8]` zero.
- R4: A byte write uses one bus operation with `mem_we` high and only the addressed bank enabled. The byte from `wdata[7:0]` is placed on that bank's data lane: bits 7..0 for the even bank, bits 15..8 for the odd bank.
- R5: A word at an even address uses one bus operation with `mem_be`=2'b11. On a write, `wdata` is driven unchanged. On a read, `rdata` is {byte A+1, byte A}.
- R6: A word read at odd address A uses two bus operations. The first goes to word address (A−1)/2 with `mem_be`=2'b10. The second goes to word address (A+1)/2 with `mem_be`=2'b01. The result is low byte = byte A and high byte = byte A+1.
- R7: A word write at odd address A uses the same two bus operations as R6. The first carries `wdata[7:0]` on lane 15..8. The second carries `wdata[15:8]` on lane 7..0.
- R8: A request is taken when `req` is high and `busy` is low at a clock edge. Bus operations start in the next cycle, one after another. `done` pulses for one cycle in the cycle after the last bus operation. `busy` is high from the first bus operation through the `done` cycle. `rdata` holds the read result in the `done` cycle of a read and is zero at every other time.
- R9: A request raised while `busy` is high is ignored: no extra bus operation and no extra `done` follows.
- R10: During and after reset, with no request, `busy`, `done` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe from the core |
| wr | input | 1 | 1 = write, 0 = read |
| word | input | 1 | 1 = 16-bit word, 0 = byte |
| seg | input | 16 | Segment value |
| off | input | 16 | Offset value |
| wdata | input | 16 | Write data; a byte uses bits 7..0 |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result in the done cycle |
| mem_en | output | 1 | Bus operation valid |
| mem_we | output | 1 | Bus operation is a write |
| mem_addr | output | 19 | Word address (linear address bits 19..1) |
| mem_be | output | 2 | Bank enables: bit 1 odd bank, bit 0 even bank |
| mem_wdata | output | 16 | Write data lanes |
| mem_rdata | input | 16 | Read data, valid the cycle after the operation |

## Verification
The bench aims at odd-address words, where several faults are possible. A design that forgot to split them would fetch the wrong word with both banks enabled. A design that skipped the swap would return the two bytes in reversed order. A design that left both lanes enabled on a split write would overwrite a neighbouring byte, and that corruption is caught by reading the byte back later. The top of the address space is also tested: the carry out of the 20-bit sum and of the second-half word address must be dropped, or the access lands at the wrong place. A request held high while the unit is busy would, in a faulty design, start a surplus bus operation or a second `done` pulse.

// File: rtl/segbank_pkg.sv
package segbank_pkg;
  localparam int SEG_W   = 16;
  localparam int OFF_W   = 16;
  localparam int SHIFT   = 4;
  localparam int ADDR_W  = 20;
  localparam int WADDR_W = ADDR_W - 1;
  localparam int BYTE_W  = 8;
  localparam int DATA_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS1, ST_BUS2, ST_LAST} seq_t;

  // Shifted segment plus offset; the carry beyond ADDR_W is dropped.
  function automatic logic [ADDR_W-1:0] form_linear(input logic [SEG_W-1:0] s,
                                                    input logic [OFF_W-1:0] o);
    logic [ADDR_W-1:0] base;
    base = ADDR_W'(s) << SHIFT;
    return base + ADDR_W'(o);
  endfunction

  // Bank enables for one bus operation.
  function automatic logic [1:0] bank_enables(input logic second, input logic is_word,
                                              input logic odd);
    if (second)       return 2'b01;
    else if (!is_word) return odd ? 2'b10 : 2'b01;
    else if (odd)      return 2'b10;
    else               return 2'b11;
  endfunction

  // Place write bytes on the lanes the enabled banks read from.
  function automatic logic [DATA_W-1:0] lane_wdata(input logic is_word, input logic odd,
                                                   input logic [DATA_W-1:0] d);
    if (!is_word)  return {d[BYTE_W-1:0], d[BYTE_W-1:0]};
    else if (odd)  return {d[BYTE_W-1:0], d[DATA_W-1:BYTE_W]};
    else           return d;
  endfunction

  // Put read bytes back into core order.
  function automatic logic [DATA_W-1:0] gather_read(input logic is_word, input logic odd,
                                                    input logic [BYTE_W-1:0] held,
                                                    input logic [DATA_W-1:0] bus);
    if (!is_word)
      return {{BYTE_W{1'b0}}, (odd ? bus[DATA_W-1:BYTE_W] : bus[BYTE_W-1:0])};
    else if (odd)
      return {bus[BYTE_W-1:0], held};
    else
      return bus;
  endfunction
endpackage

// File: rtl/segbank_addr.sv
module segbank_addr
  import segbank_pkg::*;
(
  input  logic [SEG_W-1:0]   seg,
  input  logic [OFF_W-1:0]   off,
  input  logic               word,
  output logic               odd,
  output logic               split,
  output logic [WADDR_W-1:0] w_first,
  output logic [WADDR_W-1:0] w_second
);
  logic [ADDR_W-1:0] lin;

  always_comb begin
    lin      = form_linear(seg, off);
    odd      = lin[0];
    split    = word & lin[0];
    w_first  = lin[ADDR_W-1:1];
    w_second = lin[ADDR_W-1:1] + WADDR_W'(1);
  end
endmodule

// File: rtl/segbank_ctrl.sv
module segbank_ctrl
  import segbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               wr,
  input  logic               word,
  input  logic               odd,
  input  logic               split,
  input  logic [WADDR_W-1:0] w_first,
  input  logic [WADDR_W-1:0] w_second,
  input  logic [DATA_W-1:0]  wdata,
  output logic               accept,
  output logic               busy,
  output logic               phase1,
  output logic               phase2,
  output logic               finish,
  output logic               q_wr,
  output logic               q_word,
  output logic               q_odd,
  output logic [WADDR_W-1:0] q_w1,
  output logic [WADDR_W-1:0] q_w2,
  output logic [DATA_W-1:0]  q_wd
);
  seq_t st, st_nx;
  logic q_split;

  assign accept = req && (st == ST_IDLE);
  assign busy   = (st != ST_IDLE);
  assign phase1 = (st == ST_BUS1);
  assign phase2 = (st == ST_BUS2);
  assign finish = (st == ST_LAST);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (accept) st_nx = ST_BUS1;
      ST_BUS1: st_nx = q_split ? ST_BUS2 : ST_LAST;
      ST_BUS2: st_nx = ST_LAST;
      ST_LAST: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      q_wr    <= 1'b0;
      q_word  <= 1'b0;
      q_odd   <= 1'b0;
      q_split <= 1'b0;
      q_w1    <= '0;
      q_w2    <= '0;
      q_wd    <= '0;
    end else begin
      st <= st_nx;
      if (accept) begin
        q_wr    <= wr;
        q_word  <= word;
        q_odd   <= odd;
        q_split <= split;
        q_w1    <= w_first;
        q_w2    <= w_second;
        q_wd    <= wdata;
      end
    end
  end
endmodule

// File: rtl/segbank_lanes.sv
module segbank_lanes
  import segbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phase1,
  input  logic               phase2,
  input  logic               finish,
  input  logic               q_wr,
  input  logic               q_word,
  input  logic               q_odd,
  input  logic [WADDR_W-1:0] q_w1,
  input  logic [WADDR_W-1:0] q_w2,
  input  logic [DATA_W-1:0]  q_wd,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [1:0]         mem_be,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               done,
  output logic [DATA_W-1:0]  rdata
);
  logic [BYTE_W-1:0] held;

  // Byte from the first half of a split read, delivered on the high lane.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held <= '0;
    else if (phase2) held <= mem_rdata[DATA_W-1:BYTE_W];
  end

  always_comb begin
    mem_en    = phase1 | phase2;
    mem_we    = mem_en & q_wr;
    mem_addr  = phase2 ? q_w2 : q_w1;
    mem_be    = mem_en ? bank_enables(phase2, q_word, q_odd) : 2'b00;
    mem_wdata = lane_wdata(q_word, q_odd, q_wd);
    done      = finish;
    rdata     = (finish && !q_wr) ? gather_read(q_word, q_odd, held, mem_rdata) : '0;
  end
endmodule

// File: rtl/segbank_access.sv
module segbank_access
  import segbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               wr,
  input  logic               word,
  input  logic [SEG_W-1:0]   seg,
  input  logic [OFF_W-1:0]   off,
  input  logic [DATA_W-1:0]  wdata,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [1:0]         mem_be,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata
);
  logic               odd, split, accept, phase1, phase2, finish;
  logic               q_wr, q_word, q_odd;
  logic [WADDR_W-1:0] w_first, w_second, q_w1, q_w2;
  logic [DATA_W-1:0]  q_wd;

  segbank_addr u_addr (
    .seg(seg), .off(off), .word(word),
    .odd(odd), .split(split), .w_first(w_first), .w_second(w_second)
  );

  segbank_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .word(word),
    .odd(odd), .split(split), .w_first(w_first), .w_second(w_second), .wdata(wdata),
    .accept(accept), .busy(busy), .phase1(phase1), .phase2(phase2), .finish(finish),
    .q_wr(q_wr), .q_word(q_word), .q_odd(q_odd), .q_w1(q_w1), .q_w2(q_w2), .q_wd(q_wd)
  );

  segbank_lanes u_lanes (
    .clk(clk), .rst_n(rst_n), .phase1(phase1), .phase2(phase2), .finish(finish),
    .q_wr(q_wr), .q_word(q_word), .q_odd(q_odd), .q_w1(q_w1), .q_w2(q_w2), .q_wd(q_wd),
    .mem_rdata(mem_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .done(done), .rdata(rdata)
  );
endmodule

// File: rtl/segbank_access_chk.sv
module segbank_access_chk #(
  parameter int WAW = 19
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           accept,
  input logic           mem_en,
  input logic [1:0]     mem_be,
  input logic [WAW-1:0] mem_addr,
  input logic           q_word,
  input logic           q_odd
);
  // R9: nothing is taken while an access runs
  a_r9_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: busy stays up until the done cycle
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R8: done follows a bus operation
  a_r8_done_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_en));

  // R10: quiet bus and no done while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_en && !done));

  // R3 and R4: byte access enables one bank only
  a_r3_byte_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !q_word) |-> ($countones(mem_be) == 1));

  // R5: aligned word enables both banks
  a_r5_even_word_both: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && q_word && !q_odd) |-> (mem_be == 2'b11));

  // R6: odd word second half goes to the next word on the even bank
  a_r6_split_second: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && q_word && q_odd && mem_be == 2'b10) |=>
      (mem_en && mem_be == 2'b01 && mem_addr == WAW'($past(mem_addr) + WAW'(1))));
endmodule

bind segbank_access segbank_access_chk #(.WAW(segbank_pkg::WADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .accept(accept),
  .mem_en(mem_en), .mem_be(mem_be), .mem_addr(mem_addr),
  .q_word(q_word), .q_odd(q_odd)
);

// File: tb/segbank_access_test.sv
module segbank_access_test;
  localparam int SPACE = 1048576;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, word = 1'b0;
  logic [15:0] seg = '0, off = '0, wdata = '0;
  logic        busy, done, mem_en, mem_we;
  logic [15:0] rdata, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [18:0] mem_addr;
  logic [1:0]  mem_be;

  always #4 clk = ~clk;

  segbank_access uut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .word(word),
    .seg(seg), .off(off), .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] seed_byte(input int a);
    return 8'((a * 37) ^ (a >> 7) ^ 8'h5A);
  endfunction

  // Memory attached to the bus
  logic [7:0] bmem [int];
  function automatic logic [7:0] bget(input int a);
    return bmem.exists(a) ? bmem[a] : seed_byte(a);
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      int wa;
      wa = int'(mem_addr) * 2;
      mem_rdata <= {bget(wa + 1), bget(wa)};
      if (mem_we) begin
        if (mem_be[0]) bmem[wa]     = mem_wdata[7:0];
        if (mem_be[1]) bmem[wa + 1] = mem_wdata[15:8];
      end
    end
  end

  // Reference model: shadow memory and expected per-cycle outputs
  logic [7:0] smem [int];
  function automatic logic [7:0] sget(input int a);
    return smem.exists(a) ? smem[a] : seed_byte(a);
  endfunction

  typedef struct {
    bit busy; bit done; bit en; bit we;
    int addr; bit [1:0] be; bit [15:0] wd; bit [15:0] rd;
    string tag; string atag;
  } exp_t;
  exp_t eq[$];

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string idle_tag = "R10 idle";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic exp_t rec(input bit b, input bit d, input bit en, input bit we,
                               input int addr, input bit [1:0] be, input bit [15:0] wd,
                               input bit [15:0] rd, input string tag, input string atag);
    exp_t e;
    e.busy = b; e.done = d; e.en = en; e.we = we; e.addr = addr; e.be = be;
    e.wd = wd; e.rd = rd; e.tag = tag; e.atag = atag;
    return e;
  endfunction

  task automatic tick();
    exp_t e;
    logic [15:0] m;
    @(posedge clk); #1;
    if (eq.size() > 0) e = eq.pop_front();
    else e = rec(0, 0, 0, 0, 0, 2'b00, 16'h0, 16'h0, idle_tag, idle_tag);
    chk(busy === e.busy, "R8", "busy", busy, e.busy);
    chk(done === e.done, "R8", "done", done, e.done);
    chk(mem_en === e.en, e.tag, "mem_en", mem_en, e.en);
    if (e.en) begin
      chk(int'(mem_addr) == e.addr, e.atag, "mem_addr", mem_addr, e.addr);
      chk(mem_be === e.be, e.tag, "mem_be", mem_be, e.be);
      chk(mem_we === e.we, e.tag, "mem_we", mem_we, e.we);
      if (e.we) begin
        m = {{8{e.be[1]}}, {8{e.be[0]}}};
        chk((mem_wdata & m) === (e.wd & m), e.tag, "mem_wdata", mem_wdata & m, e.wd & m);
      end
    end
    chk(rdata === e.rd, e.done ? e.tag : "R8", "rdata", rdata, e.rd);
  endtask

  // Queue the expected cycles of one access and present it on the inputs.
  task automatic start(input bit w, input bit wd_word, input logic [15:0] s,
                       input logic [15:0] o, input logic [15:0] d,
                       input string tag, input string atag);
    int a, a1;
    bit [15:0] r;
    a  = (int'(s) * 16 + int'(o)) % SPACE;
    a1 = (a + 1) % SPACE;
    if (!wd_word) begin
      r = w ? 16'h0 : {8'h00, sget(a)};
      eq.push_back(rec(1, 0, 1, w, a / 2, (a % 2) ? 2'b10 : 2'b01,
                       {d[7:0], d[7:0]}, 16'h0, tag, atag));
      eq.push_back(rec(1, 1, 0, 0, 0, 2'b00, 16'h0, r, tag, atag));
      if (w) smem[a] = d[7:0];
    end else if (a % 2 == 0) begin
      r = w ? 16'h0 : {sget(a1), sget(a)};
      eq.push_back(rec(1, 0, 1, w, a / 2, 2'b11, d, 16'h0, tag, atag));
      eq.push_back(rec(1, 1, 0, 0, 0, 2'b00, 16'h0, r, tag, atag));
    end else begin
      r = w ? 16'h0 : {sget(a1), sget(a)};
      eq.push_back(rec(1, 0, 1, w, (a - 1) / 2, 2'b10, {d[7:0], 8'h00}, 16'h0, tag, atag));
      eq.push_back(rec(1, 0, 1, w, a1 / 2, 2'b01, {8'h00, d[15:8]}, 16'h0, tag, atag));
      eq.push_back(rec(1, 1, 0, 0, 0, 2'b00, 16'h0, r, tag, atag));
    end
    if (w && wd_word) begin
      smem[a]  = d[7:0];
      smem[a1] = d[15:8];
    end
    req = 1'b1; wr = w; word = wd_word; seg = s; off = o; wdata = d;
  endtask

  task automatic drain();
    while (eq.size() > 0) tick();
    tick();
  endtask

  task automatic access(input bit w, input bit wd_word, input logic [15:0] s,
                        input logic [15:0] o, input logic [15:0] d,
                        input string tag, input string atag);
    start(w, wd_word, s, o, d, tag, atag);
    tick();
    req = 1'b0;
    drain();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    logic [31:0] lf;
    // R10: outputs quiet while reset is held and just after release
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1'b1;
    tick();
    tick();
    idle_tag = "R8 idle";

    // R4: byte writes to each bank; R3: reading them back
    access(1, 0, 16'h0100, 16'h0020, 16'h00A5, "R4 byte write even", "R1");
    access(1, 0, 16'h0100, 16'h0021, 16'h003C, "R4 byte write odd", "R1");
    access(0, 0, 16'h0100, 16'h0020, 16'h0000, "R3 byte read even", "R1");
    access(0, 0, 16'h0100, 16'h0021, 16'h0000, "R3 byte read odd", "R1");

    // R5: aligned word write then read
    access(1, 1, 16'h2000, 16'h0BAE, 16'hBEEF, "R5 even word write", "R1");
    access(0, 1, 16'h2000, 16'h0BAE, 16'h0000, "R5 even word read", "R1");

    // R6: odd word read of untouched memory
    access(0, 1, 16'h0020, 16'h007D, 16'h0000, "R6 odd word read", "R1");

    // R7: odd word write, then neighbours and the word read back
    access(1, 1, 16'h0300, 16'h0041, 16'h1234, "R7 odd word write", "R1");
    access(0, 1, 16'h0300, 16'h0041, 16'h0000, "R7 odd word readback", "R1");
    access(0, 0, 16'h0300, 16'h0040, 16'h0000, "R7 neighbour below kept", "R1");
    access(0, 0, 16'h0300, 16'h0043, 16'h0000, "R7 neighbour above kept", "R1");

    // R1: distinct segment/offset pairs naming the same byte
    access(1, 0, 16'h1234, 16'h5678, 16'h0077, "R1 alias write", "R1");
    access(0, 0, 16'h1000, 16'h79B8, 16'h0000, "R1 alias read", "R1");

    // R2: sum overflow wraps; odd word at the last byte wraps to word 0
    access(1, 1, 16'hFFFF, 16'h0010, 16'hC0DE, "R5 wrapped even word", "R2");
    access(1, 1, 16'hF000, 16'hFFFF, 16'hA1B2, "R7 top odd word write", "R2");
    access(0, 1, 16'hF000, 16'hFFFF, 16'h0000, "R6 top odd word read", "R2");
    access(0, 1, 16'h0000, 16'h0000, 16'h0000, "R2 bottom word read", "R1");

    // R9: request held high during a split access is dropped
    start(0, 1, 16'h0040, 16'h0003, 16'h0000, "R9 busy first access", "R1");
    tick();
    seg = 16'h7777; off = 16'h0011; wr = 1'b1; wdata = 16'hFFFF;
    tick();
    req = 1'b0;
    idle_tag = "R9 no extra access";
    drain();
    tick();
    idle_tag = "R8 idle";
    access(0, 0, 16'h7777, 16'h0011, 16'h0000, "R9 target untouched", "R1");

    // Mixed patterns in a small window so reads hit earlier writes
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 80; i++) begin
      lf = lf * 32'd1103515245 + 32'd12345;
      access(lf[20], lf[21], {12'h0, lf[27:24]}, {8'h0, lf[15:8]}, lf[31:16],
             lf[21] ? (lf[8] ? "R6 mixed odd word" : "R5 mixed even word")
                    : (lf[20] ? "R4 mixed byte write" : "R3 mixed byte read"), "R1");
    end

    summary();
  end
endmodule